// File: doc/BRIEF.md
# Split Bulk/Control Transaction Buffer Pool

This block is the non-periodic side of a transaction translator. A high-speed host hands it bulk or control work as start-split requests; each accepted request parks the endpoint identity (device address, endpoint number, direction) and one payload word in a free buffer. The pool then hands the parked transactions, oldest first, to a full/low-speed issue engine. It does this only while the periodic pipeline has nothing pending and no other non-periodic transaction is on the classic wire. The issue engine reports one result word per transaction, which is kept in the same buffer until the host collects it with a complete-split for that endpoint.

Each buffer walks a fixed lifecycle: empty, waiting to issue, on the wire, result ready, and back to empty. Because there are several buffers, a second endpoint's transaction can run on the classic bus while the first endpoint's result still waits for its complete-split. This keeps the slow bus busy. A synchronous clear input drops every buffer at once and models a translator reset request.

Top module: `nsp_split_pool`

## Requirements
- R1: The pool holds `NBUF` transactions at the same time, and `NBUF` must be at least 2; a smaller value stops elaboration.
- R2: Every start-split presented with `ss_valid` gets `ss_resp_valid` on the next cycle. If a buffer was free, `ss_ack` is 1 (ACK) and the transaction is stored.
- R3: A start-split that arrives while all `NBUF` buffers are occupied gets `ss_ack` = 0 (NAK) and is not stored.
- R4: `issue_valid` is low whenever `periodic_pending` is high, and also low while a previously issued transaction has not yet returned its result.
- R5: Waiting transactions are offered on `issue_*` in the order their start-splits were accepted. A transaction leaves the queue when `issue_valid` and `issue_ready` are both high.
- R6: A `result_valid` pulse while a transaction is on the wire stores `result_data` in that transaction's buffer and marks the buffer ready. That word is later returned on `cs_result`.
- R7: Every complete-split gets `cs_resp_valid` on the next cycle. If the matching buffer is not yet ready, `cs_code` = 0 (NYET) and `cs_result` = 0.
- R8: A complete-split that matches a ready buffer returns `cs_code` = 1 (DONE) with the stored result, and frees that buffer.
- R9: A complete-split is matched on address, endpoint number and direction together. If none of the occupied buffers matches, the answer is `cs_code` = 2 (STALL) with `cs_result` = 0.
- R10: A second transaction may be issued while the first one's ready result still waits for its complete-split.
- R11: `tt_clear` empties every buffer and drops the in-flight transaction. A result that arrives afterwards is ignored, and no responses are produced for the cycle in which `tt_clear` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tt_clear | input | 1 | Synchronous translator clear |
| periodic_pending | input | 1 | Periodic work waits for the classic bus |
| ss_valid | input | 1 | Start-split request strobe |
| ss_dev | input | 7 | Start-split device address |
| ss_ep | input | 4 | Start-split endpoint number |
| ss_dir_in | input | 1 | Start-split direction (1 = IN) |
| ss_payload | input | DW | Start-split payload word |
| ss_resp_valid | output | 1 | Start-split response strobe |
| ss_ack | output | 1 | 1 = ACK, 0 = NAK |
| cs_valid | input | 1 | Complete-split request strobe |
| cs_dev | input | 7 | Complete-split device address |
| cs_ep | input | 4 | Complete-split endpoint number |
| cs_dir_in | input | 1 | Complete-split direction |
| cs_resp_valid | output | 1 | Complete-split response strobe |
| cs_code | output | 2 | 0 NYET, 1 DONE, 2 STALL |
| cs_result | output | RW | Returned result word |
| issue_valid | output | 1 | Transaction offered to the classic engine |
| issue_ready | input | 1 | Classic engine takes the offer |
| issue_dev | output | 7 | Offered device address |
| issue_ep | output | 4 | Offered endpoint number |
| issue_dir_in | output | 1 | Offered direction |
| issue_payload | output | DW | Offered payload word |
| result_valid | input | 1 | Classic result strobe |
| result_data | input | RW | Classic result word |

## Verification
The stimulus first fills the pool while periodic work is held pending. This separates pure storage and NAK-on-full behaviour from arbitration, and it probes complete-splits against unfinished buffers, unknown endpoints, and an endpoint whose direction is flipped. Releasing the periodic hold with several transactions queued shows whether issue order follows acceptance order. Overlapping a later issue with an earlier complete-split tells a truly multi-buffer pool apart from one that serialises everything. A clear applied with a transaction in flight, followed by a late result, shows whether stale results can leak into a freshly emptied pool.

// File: rtl/nsp_pkg.sv
package nsp_pkg;

    typedef struct packed {
        logic [6:0] dev;
        logic [3:0] ep;
        logic       dir_in;
    } ep_key_t;

    localparam int KEY_W = $bits(ep_key_t);

    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_WIRE  = 2'd2,
        SLOT_READY = 2'd3
    } slot_st_e;

    typedef enum logic [1:0] {
        CS_NYET  = 2'd0,
        CS_DONE  = 2'd1,
        CS_STALL = 2'd2
    } cs_code_e;

    function automatic ep_key_t make_key(input logic [6:0] dev, input logic [3:0] ep,
                                         input logic dir_in);
        ep_key_t k;
        k.dev    = dev;
        k.ep     = ep;
        k.dir_in = dir_in;
        return k;
    endfunction

endpackage

// File: rtl/nsp_order_fifo.sv
module nsp_order_fifo #(
    parameter int DEPTH = 2,
    parameter int IW    = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [IW-1:0] push_idx,
    input  logic          pop,
    output logic          head_valid,
    output logic [IW-1:0] head_idx
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [IW-1:0] ring [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head_valid = (count != '0);
    assign head_idx   = ring[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                ring[wr_ptr] <= push_idx;
                wr_ptr       <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/nsp_key_match.sv
module nsp_key_match
    import nsp_pkg::*;
#(
    parameter int NBUF = 2
) (
    input  ep_key_t [NBUF-1:0] slot_key,
    input  logic    [NBUF-1:0] slot_used,
    input  ep_key_t            probe,
    output logic    [NBUF-1:0] hit
);
    for (genvar g = 0; g < NBUF; g++) begin : g_cmp
        assign hit[g] = slot_used[g] && (slot_key[g] == probe);
    end
endmodule

// File: rtl/nsp_split_pool.sv
module nsp_split_pool
    import nsp_pkg::*;
#(
    parameter int NBUF = 2,
    parameter int DW   = 8,
    parameter int RW   = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tt_clear,
    input  logic          periodic_pending,
    input  logic          ss_valid,
    input  logic [6:0]    ss_dev,
    input  logic [3:0]    ss_ep,
    input  logic          ss_dir_in,
    input  logic [DW-1:0] ss_payload,
    output logic          ss_resp_valid,
    output logic          ss_ack,
    input  logic          cs_valid,
    input  logic [6:0]    cs_dev,
    input  logic [3:0]    cs_ep,
    input  logic          cs_dir_in,
    output logic          cs_resp_valid,
    output logic [1:0]    cs_code,
    output logic [RW-1:0] cs_result,
    output logic          issue_valid,
    input  logic          issue_ready,
    output logic [6:0]    issue_dev,
    output logic [3:0]    issue_ep,
    output logic          issue_dir_in,
    output logic [DW-1:0] issue_payload,
    input  logic          result_valid,
    input  logic [RW-1:0] result_data
);
    localparam int IW = $clog2(NBUF);

    // R1: a single-buffer pool cannot overlap transactions
    if (NBUF < 2) begin : g_bad_pool_size_R1
        $error("nsp_split_pool needs NBUF >= 2");
    end

    slot_st_e             slot_st  [NBUF];
    ep_key_t [NBUF-1:0]   slot_key;
    logic    [DW-1:0]     slot_pay [NBUF];
    logic    [RW-1:0]     slot_res [NBUF];
    logic    [NBUF-1:0]   slot_used;

    logic                 in_flight;
    logic [IW-1:0]        wire_idx;

    logic                 any_free;
    logic [IW-1:0]        free_idx;
    logic [NBUF-1:0]      cs_hit;
    logic                 any_hit;
    logic [IW-1:0]        hit_idx;
    logic                 head_valid;
    logic [IW-1:0]        head_idx;
    logic                 push, issue_fire;
    ep_key_t              ss_key, cs_key, head_key;

    assign ss_key = make_key(ss_dev, ss_ep, ss_dir_in);
    assign cs_key = make_key(cs_dev, cs_ep, cs_dir_in);

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        any_hit  = 1'b0;
        hit_idx  = '0;
        for (int i = NBUF - 1; i >= 0; i--) begin
            slot_used[i] = (slot_st[i] != SLOT_EMPTY);
            if (slot_st[i] == SLOT_EMPTY) begin
                any_free = 1'b1;
                free_idx = IW'(i);
            end
            if (cs_hit[i]) begin
                any_hit = 1'b1;
                hit_idx = IW'(i);
            end
        end
    end

    nsp_key_match #(.NBUF(NBUF)) u_match (
        .slot_key (slot_key),
        .slot_used(slot_used),
        .probe    (cs_key),
        .hit      (cs_hit)
    );

    assign push       = ss_valid && any_free && !tt_clear;
    assign issue_fire = issue_valid && issue_ready && !tt_clear;

    nsp_order_fifo #(.DEPTH(NBUF), .IW(IW)) u_order (
        .clk       (clk),
        .rst       (rst),
        .flush     (tt_clear),
        .push      (push),
        .push_idx  (free_idx),
        .pop       (issue_fire),
        .head_valid(head_valid),
        .head_idx  (head_idx)
    );

    assign head_key      = slot_key[head_idx];
    assign issue_valid   = head_valid && !in_flight && !periodic_pending;
    assign issue_dev     = head_key.dev;
    assign issue_ep      = head_key.ep;
    assign issue_dir_in  = head_key.dir_in;
    assign issue_payload = slot_pay[head_idx];

    always_ff @(posedge clk) begin
        if (rst || tt_clear) begin
            for (int i = 0; i < NBUF; i++) slot_st[i] <= SLOT_EMPTY;
            in_flight     <= 1'b0;
            wire_idx      <= '0;
            ss_resp_valid <= 1'b0;
            ss_ack        <= 1'b0;
            cs_resp_valid <= 1'b0;
            cs_code       <= CS_NYET;
            cs_result     <= '0;
        end else begin
            ss_resp_valid <= ss_valid;
            ss_ack        <= ss_valid && any_free;
            if (push) begin
                slot_st[free_idx]  <= SLOT_WAIT;
                slot_key[free_idx] <= ss_key;
                slot_pay[free_idx] <= ss_payload;
            end

            if (issue_fire) begin
                slot_st[head_idx] <= SLOT_WIRE;
                wire_idx          <= head_idx;
                in_flight         <= 1'b1;
            end else if (result_valid && in_flight) begin
                slot_st[wire_idx]  <= SLOT_READY;
                slot_res[wire_idx] <= result_data;
                in_flight          <= 1'b0;
            end

            cs_resp_valid <= cs_valid;
            cs_result     <= '0;
            cs_code       <= CS_NYET;
            if (cs_valid) begin
                if (!any_hit) begin
                    cs_code <= CS_STALL;
                end else if (slot_st[hit_idx] == SLOT_READY) begin
                    cs_code          <= CS_DONE;
                    cs_result        <= slot_res[hit_idx];
                    slot_st[hit_idx] <= SLOT_EMPTY;
                end
            end
        end
    end
endmodule

// File: rtl/nsp_pool_checker.sv
module nsp_pool_checker (
    input logic clk,
    input logic rst,
    input logic tt_clear,
    input logic periodic_pending,
    input logic ss_valid,
    input logic ss_resp_valid,
    input logic cs_valid,
    input logic cs_resp_valid,
    input logic issue_valid,
    input logic issue_ready,
    input logic result_valid,
    input logic in_flight
);
    assert_ss_answered_R2: assert property (@(posedge clk) disable iff (rst)
        (ss_valid && !tt_clear) |=> ss_resp_valid);

    assert_periodic_first_R4: assert property (@(posedge clk) disable iff (rst)
        periodic_pending |-> !issue_valid);

    assert_result_lands_R6: assert property (@(posedge clk) disable iff (rst)
        (result_valid && in_flight && !tt_clear) |=> !in_flight);

    assert_cs_answered_R7: assert property (@(posedge clk) disable iff (rst)
        (cs_valid && !tt_clear) |=> cs_resp_valid);

    assert_one_on_wire_R10: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_ready) |=> !issue_valid);

    assert_clear_silences_R11: assert property (@(posedge clk) disable iff (rst)
        tt_clear |=> (!ss_resp_valid && !cs_resp_valid && !in_flight));
endmodule

bind nsp_split_pool nsp_pool_checker u_chk (
    .clk             (clk),
    .rst             (rst),
    .tt_clear        (tt_clear),
    .periodic_pending(periodic_pending),
    .ss_valid        (ss_valid),
    .ss_resp_valid   (ss_resp_valid),
    .cs_valid        (cs_valid),
    .cs_resp_valid   (cs_resp_valid),
    .issue_valid     (issue_valid),
    .issue_ready     (issue_ready),
    .result_valid    (result_valid),
    .in_flight       (in_flight)
);

// File: tb/sim_nsp_split_pool.sv
`timescale 1ns/1ps
module sim_nsp_split_pool;
    localparam int NB = 3;
    localparam int DW = 8;
    localparam int RW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, tt_clear, pp;
    logic ss_valid, ss_dir_in, cs_valid, cs_dir_in, rdy, res_v;
    logic [6:0] ss_dev, cs_dev, issue_dev;
    logic [3:0] ss_ep, cs_ep, issue_ep;
    logic [DW-1:0] ss_payload, issue_payload;
    logic [RW-1:0] res_d, cs_result;
    logic ss_resp_valid, ss_ack, cs_resp_valid, issue_valid, issue_dir_in;
    logic [1:0] cs_code;

    nsp_split_pool #(.NBUF(NB), .DW(DW), .RW(RW)) u0 (
        .clk(clk), .rst(rst), .tt_clear(tt_clear), .periodic_pending(pp),
        .ss_valid(ss_valid), .ss_dev(ss_dev), .ss_ep(ss_ep), .ss_dir_in(ss_dir_in),
        .ss_payload(ss_payload), .ss_resp_valid(ss_resp_valid), .ss_ack(ss_ack),
        .cs_valid(cs_valid), .cs_dev(cs_dev), .cs_ep(cs_ep), .cs_dir_in(cs_dir_in),
        .cs_resp_valid(cs_resp_valid), .cs_code(cs_code), .cs_result(cs_result),
        .issue_valid(issue_valid), .issue_ready(rdy), .issue_dev(issue_dev),
        .issue_ep(issue_ep), .issue_dir_in(issue_dir_in), .issue_payload(issue_payload),
        .result_valid(res_v), .result_data(res_d)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // behavioural model: entries kept in acceptance order
    int q_key[$];
    int q_dat[$];
    int q_st[$];   // 0 waiting, 1 on wire, 2 ready
    int q_res[$];
    int e_ss_rv = 0, e_ss_ack = 0, e_cs_rv = 0, e_cs_code = 0, e_cs_res = 0;

    function automatic int keyof(input int d, input int e, input int dir);
        return (d << 5) | (e << 1) | dir;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        int busy = -1;
        int first_wait = -1;
        int hit = -1;
        int exp_iv;
        int fire;
        #1;
        for (int i = 0; i < q_st.size(); i++) begin
            if (q_st[i] == 1) busy = i;
            if (q_st[i] == 0 && first_wait < 0) first_wait = i;
        end
        exp_iv = (busy < 0 && first_wait >= 0 && !pp) ? 1 : 0;
        chk("R4 issue_valid", int'(issue_valid), exp_iv);
        if (exp_iv == 1) begin
            chk("R5 issue key", keyof(issue_dev, issue_ep, issue_dir_in), q_key[first_wait]);
            chk("R5 issue payload", int'(issue_payload), q_dat[first_wait]);
        end
        chk("R2 ss_resp_valid", int'(ss_resp_valid), e_ss_rv);
        if (e_ss_rv == 1) chk(e_ss_ack == 1 ? "R2 ss_ack" : "R3 ss_ack", int'(ss_ack), e_ss_ack);
        chk("R7 cs_resp_valid", int'(cs_resp_valid), e_cs_rv);
        if (e_cs_rv == 1) begin
            chk(e_cs_code == 0 ? "R7 cs_code" : (e_cs_code == 1 ? "R8 cs_code" : "R9 cs_code"),
                int'(cs_code), e_cs_code);
            chk("R6 cs_result", int'(cs_result), e_cs_res);
        end

        if (tt_clear) begin
            q_key.delete(); q_dat.delete(); q_st.delete(); q_res.delete();
            e_ss_rv = 0; e_ss_ack = 0; e_cs_rv = 0; e_cs_code = 0; e_cs_res = 0;
        end else begin
            e_ss_rv  = int'(ss_valid);
            e_ss_ack = (ss_valid && q_st.size() < NB) ? 1 : 0;
            e_cs_rv  = int'(cs_valid);
            e_cs_code = 0;
            e_cs_res  = 0;
            if (cs_valid) begin
                for (int i = 0; i < q_key.size(); i++)
                    if (q_key[i] == keyof(cs_dev, cs_ep, cs_dir_in)) hit = i;
                if (hit < 0) e_cs_code = 2;
                else if (q_st[hit] == 2) begin
                    e_cs_code = 1;
                    e_cs_res  = q_res[hit];
                end
            end
            fire = (exp_iv == 1 && rdy) ? 1 : 0;
            if (fire == 1) q_st[first_wait] = 1;
            else if (busy >= 0 && res_v) begin
                q_st[busy]  = 2;
                q_res[busy] = int'(res_d);
            end
            if (e_cs_code == 1) begin
                q_key.delete(hit); q_dat.delete(hit); q_st.delete(hit); q_res.delete(hit);
            end
            if (e_ss_ack == 1) begin
                q_key.push_back(keyof(ss_dev, ss_ep, ss_dir_in));
                q_dat.push_back(int'(ss_payload));
                q_st.push_back(0);
                q_res.push_back(0);
            end
        end
        @(posedge clk);
        @(negedge clk);
        ss_valid = 0; cs_valid = 0; res_v = 0; tt_clear = 0;
    endtask

    task automatic start_split(input int d, input int e, input int dir, input int dat);
        ss_valid = 1; ss_dev = 7'(d); ss_ep = 4'(e); ss_dir_in = dir[0]; ss_payload = DW'(dat);
        step();
    endtask

    task automatic complete_split(input int d, input int e, input int dir);
        cs_valid = 1; cs_dev = 7'(d); cs_ep = 4'(e); cs_dir_in = dir[0];
        step();
    endtask

    task automatic give_result(input int r);
        res_v = 1; res_d = RW'(r);
        step();
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst = 1; tt_clear = 0; pp = 0; rdy = 0; res_v = 0; res_d = '0;
        ss_valid = 0; ss_dev = '0; ss_ep = '0; ss_dir_in = 0; ss_payload = '0;
        cs_valid = 0; cs_dev = '0; cs_ep = '0; cs_dir_in = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // reset state
        chk("reset issue_valid", int'(issue_valid), 0);
        chk("reset ss_resp_valid", int'(ss_resp_valid), 0);
        chk("reset cs_resp_valid", int'(cs_resp_valid), 0);
        step();

        // R1 R2 R3: fill all NB buffers under periodic hold, then NAK
        pp = 1; rdy = 1;
        start_split(1, 1, 0, 8'h11);
        start_split(2, 3, 0, 8'h22);
        start_split(3, 2, 1, 8'h33);
        start_split(4, 5, 0, 8'h44);
        // R7: not ready -> NYET; R9: unknown key and flipped direction -> STALL
        complete_split(1, 1, 0);
        complete_split(9, 9, 1);
        complete_split(1, 1, 1);
        repeat (3) step();   // R4: held by periodic work

        // R5: oldest first once periodic work clears
        pp = 0;
        step();
        step();              // R4: one on the wire at a time
        give_result(8'h5A);  // R6
        // R10: second endpoint issues while first result waits
        complete_split(2, 3, 0);
        complete_split(1, 1, 0); // R8 returns 0x5A
        complete_split(1, 1, 0); // R8: buffer now free -> STALL
        start_split(4, 5, 0, 8'h44);
        give_result(8'hB1);
        step();
        pp = 1; step(); pp = 0;
        give_result(8'hC3);
        step();
        complete_split(3, 2, 1);
        complete_split(2, 3, 0);

        // R11: clear with a transaction on the wire, then a late result
        start_split(6, 6, 1, 8'h66);
        rdy = 0; step(); rdy = 1;
        tt_clear = 1; step();
        give_result(8'hEE);
        complete_split(4, 5, 0);
        complete_split(6, 6, 1);
        start_split(7, 4, 0, 8'h77);
        step();
        give_result(8'h19);
        complete_split(7, 4, 0);
        repeat (2) step();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule